// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns internal bus cycles into five external chip select strobes. Each select owns a 16-bit base tag, a 16-bit address mask, a valid flag and a 16-bit control word. The control word carries six address-space mask bits, a wait-state count, an auto-acknowledge enable, a port-size code and read/write burst enables. When a bus cycle starts, the upper 16 address bits and the cycle's address-space code are compared against every select. The lowest-numbered select that matches is driven for the whole cycle. The block either times the programmed wait states and raises the transfer acknowledge itself, or passes an external acknowledge through.

Straight after reset, select 0 acts as a global boot select. It claims every address, so a boot memory can be read before any register is written. It leaves that mode once its control word is written with the valid bit set, and from then on it decodes through its base and mask. Port size and burst enables are not acted on here. They are reported on outputs for the data path to use.

Top module: `csdec_top`

## Requirements
- R1: While reset is active, and right after it, `cs_act` is all zero, `ta` is 0 and `port_size`, `burst_rd` and `burst_wr` are 0. A reset that arrives during an active cycle drops the select at once.
- R2: After reset, select 0 is in boot mode. A cycle at any address, in any of the six spaces, asserts `cs_act[0]` with 15 wait states (select high for 16 cycles, `ta` in the 16th), port size 2 and both burst enables 0.
- R3: Selects 1 to 4 never assert while their valid bit (control bit 0) is 0, even when the address matches.
- R4: A select matches when `((cyc_addr[31:16] ^ base) & ~mask) == 0`, where mask bits set to 1 are don't-care. The select rises in the cycle after the edge that samples `cyc_start`.
- R5: Space codes are 0 user data, 1 user code, 2 supervisor data, 3 supervisor code, 4 interrupt acknowledge and 5 DMA master. Control bit 1+code set to 1 blocks that space, and the cycle then runs with no select and no `ta`. Codes 6 and 7 select nothing.
- R6: When several selects match, only the lowest-numbered one asserts.
- R7: With auto-acknowledge on (control bit 11), for W wait states (control bits 10:7) the select is high for W+1 cycles and `ta` is high only in the last of them.
- R8: With auto-acknowledge off, `ta` follows `ext_ack` while a select is active, and the select stays high until that happens.
- R9: The select drops in the cycle after `ta`, and at most one `cs_act` bit is ever high.
- R10: Writing select 0's control word (field 2) with bit 0 set ends boot mode. After that, select 0 decodes with its base and mask.
- R11: A `cyc_start` that arrives while a select is active is ignored. The active select and its timing do not change.
- R12: While a select is active, `port_size` shows its control bits 13:12, `burst_rd` shows bit 14 and `burst_wr` shows bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Select index written (0 to 4) |
| cfg_field | input | 2 | 0 base tag, 1 address mask, 2 control word |
| cfg_data | input | 16 | Write data |
| cyc_start | input | 1 | One-cycle pulse that starts a bus cycle |
| cyc_addr | input | 32 | Bus cycle address |
| cyc_space | input | 3 | Address-space code of the cycle |
| ext_ack | input | 1 | External acknowledge, used when auto-acknowledge is off |
| cs_act | output | 5 | Active-high chip selects |
| ta | output | 1 | Transfer acknowledge |
| port_size | output | 2 | Port-size code of the active select |
| burst_rd | output | 1 | Read-burst enable of the active select |
| burst_wr | output | 1 | Write-burst enable of the active select |

## Verification
The start pulse is sampled on one rising edge, and the select shows up in the cycle that follows. With W wait states, `ta` arrives W cycles later, and the select is gone one cycle after that. In external-acknowledge mode, `ta` lines up with whichever cycle `ext_ack` is driven in. The bench drives each access on a falling edge and then numbers the cycles after the start edge. It samples 1 ns after every falling edge, and compares the cycle where the select first appears, the number of cycles it stays high and the cycle index of `ta` against values worked out from the wait-state count or from the cycle chosen for `ext_ack`. It keeps watching for a fixed window long after the expected release, so a late, repeated or spurious select is also caught.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int SPACE_N = 6;
  localparam int WS_W    = 4;

  typedef enum logic [2:0] {
    SP_UDATA = 3'd0, SP_UCODE = 3'd1, SP_SDATA = 3'd2,
    SP_SCODE = 3'd3, SP_IACK  = 3'd4, SP_DMA   = 3'd5
  } space_e;

  typedef struct packed {
    logic               bw;
    logic               br;
    logic [1:0]         ps;
    logic               aa;
    logic [WS_W-1:0]    ws;
    logic [SPACE_N-1:0] smask;
    logic               valid;
  } cs_ctrl_t;

  typedef enum logic { ST_IDLE = 1'b0, ST_ACTIVE = 1'b1 } cyc_st_e;
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int TAG_W  = 16,
  parameter int SEL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [1:0]                    cfg_field,
  input  logic [15:0]                   cfg_data,
  output logic [NUM_CS-1:0][TAG_W-1:0]  base_o,
  output logic [NUM_CS-1:0][TAG_W-1:0]  mask_o,
  output cs_ctrl_t [NUM_CS-1:0]         ctrl_o,
  output logic                          boot_o
);
  localparam int BODY_W = $bits(cs_ctrl_t) - 1;
  localparam logic [BODY_W-1:0] CS0_BODY_RST = {1'b0, 1'b0, 2'b10, 1'b1, 4'hF, 6'b000000};

  logic [NUM_CS-1:0] valid_q, valid_d;
  logic              boot_q, boot_d;
  logic [NUM_CS-1:0] wr_base, wr_mask, wr_ctrl;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
    logic [BODY_W-1:0] body_q;
    assign wr_base[i] = cfg_we && (cfg_sel == SEL_W'(i)) && (cfg_field == 2'd0);
    assign wr_mask[i] = cfg_we && (cfg_sel == SEL_W'(i)) && (cfg_field == 2'd1);
    assign wr_ctrl[i] = cfg_we && (cfg_sel == SEL_W'(i)) && (cfg_field == 2'd2);

    always_ff @(posedge clk) begin
      if (wr_base[i]) base_o[i] <= cfg_data[TAG_W-1:0];
      if (wr_mask[i]) mask_o[i] <= cfg_data[TAG_W-1:0];
    end

    if (i == 0) begin : g_boot_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          body_q <= CS0_BODY_RST;
        else if (wr_ctrl[i]) body_q <= cfg_data[BODY_W:1];
      end
    end else begin : g_plain_body
      always_ff @(posedge clk) begin
        if (wr_ctrl[i]) body_q <= cfg_data[BODY_W:1];
      end
    end

    assign ctrl_o[i] = cs_ctrl_t'({body_q, valid_q[i]});
  end

  always_comb begin
    for (int i = 0; i < NUM_CS; i++)
      valid_d[i] = wr_ctrl[i] ? cfg_data[0] : valid_q[i];
    boot_d = boot_q && !(wr_ctrl[0] && cfg_data[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      boot_q  <= 1'b1;
    end else begin
      valid_q <= valid_d;
      boot_q  <= boot_d;
    end
  end

  assign boot_o = boot_q;
endmodule

// File: rtl/csdec_match.sv
module csdec_match
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int TAG_W  = 16
) (
  input  logic [TAG_W-1:0]              tag,
  input  logic [2:0]                    space,
  input  logic [NUM_CS-1:0][TAG_W-1:0]  base,
  input  logic [NUM_CS-1:0][TAG_W-1:0]  mask,
  input  cs_ctrl_t [NUM_CS-1:0]         ctrl,
  input  logic                          boot,
  output logic                          hit,
  output logic [NUM_CS-1:0]             sel_oh,
  output cs_ctrl_t                      sel_ctrl
);
  logic [SPACE_N-1:0] space_oh;
  logic [NUM_CS-1:0]  hit_vec;

  assign space_oh = (space < 3'(SPACE_N)) ? SPACE_N'(1) << space : '0;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
    logic tag_ok, space_ok, en_ok;
    assign space_ok = |(space_oh & ~ctrl[i].smask);
    if (i == 0) begin : g_global
      assign tag_ok = boot || (((tag ^ base[i]) & ~mask[i]) == '0);
      assign en_ok  = boot || ctrl[i].valid;
    end else begin : g_normal
      assign tag_ok = (((tag ^ base[i]) & ~mask[i]) == '0);
      assign en_ok  = ctrl[i].valid;
    end
    assign hit_vec[i] = tag_ok && en_ok && space_ok;
  end

  always_comb begin
    sel_oh   = '0;
    sel_ctrl = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_oh    = '0;
        sel_oh[i] = 1'b1;
        sel_ctrl  = ctrl[i];
      end
    end
    hit = |hit_vec;
  end
endmodule

// File: rtl/csdec_timer.sv
module csdec_timer
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  input  logic [NUM_CS-1:0] sel_oh,
  input  cs_ctrl_t          sel_ctrl,
  input  logic              ext_ack,
  output logic [NUM_CS-1:0] cs_act,
  output logic              ta,
  output logic [1:0]        port_size,
  output logic              burst_rd,
  output logic              burst_wr
);
  cyc_st_e           st_q, st_d;
  logic [WS_W-1:0]   cnt_q, cnt_d;
  logic [NUM_CS-1:0] cs_q, cs_d;
  logic              aa_q, aa_d;
  logic [1:0]        ps_q, ps_d;
  logic              br_q, br_d, bw_q, bw_d;
  logic              load_en, done;

  assign done    = (st_q == ST_ACTIVE) && (aa_q ? (cnt_q == '0) : ext_ack);
  assign load_en = (st_q == ST_IDLE) && start && hit;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; cs_d = cs_q;
    aa_d = aa_q; ps_d = ps_q; br_d = br_q; bw_d = bw_q;
    if (load_en) begin
      st_d  = ST_ACTIVE;
      cnt_d = sel_ctrl.ws;
      cs_d  = sel_oh;
      aa_d  = sel_ctrl.aa;
      ps_d  = sel_ctrl.ps;
      br_d  = sel_ctrl.br;
      bw_d  = sel_ctrl.bw;
    end else if (done) begin
      st_d = ST_IDLE;
      cs_d = '0;
      ps_d = 2'b00;
      br_d = 1'b0;
      bw_d = 1'b0;
    end else if (st_q == ST_ACTIVE && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; cs_q <= '0; aa_q <= 1'b0;
      ps_q <= 2'b00;   br_q  <= 1'b0; bw_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; cs_q <= cs_d; aa_q <= aa_d;
      ps_q <= ps_d; br_q  <= br_d;  bw_q <= bw_d;
    end
  end

  assign cs_act    = cs_q;
  assign ta        = done;
  assign port_size = ps_q;
  assign burst_rd  = br_q;
  assign burst_wr  = bw_q;
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int AW     = 32,
  localparam int TAG_W = 16,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [1:0]        cfg_field,
  input  logic [15:0]       cfg_data,
  input  logic              cyc_start,
  input  logic [AW-1:0]     cyc_addr,
  input  logic [2:0]        cyc_space,
  input  logic              ext_ack,
  output logic [NUM_CS-1:0] cs_act,
  output logic              ta,
  output logic [1:0]        port_size,
  output logic              burst_rd,
  output logic              burst_wr
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_CS-1:0][TAG_W-1:0] base_w, mask_w;
  cs_ctrl_t [NUM_CS-1:0]        ctrl_w;
  cs_ctrl_t                     sel_ctrl_w;
  logic                         boot_w, hit_w;
  logic [NUM_CS-1:0]            sel_oh_w;

  csdec_regs #(.NUM_CS(NUM_CS), .TAG_W(TAG_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_data(cfg_data),
    .base_o(base_w), .mask_o(mask_w), .ctrl_o(ctrl_w), .boot_o(boot_w)
  );

  csdec_match #(.NUM_CS(NUM_CS), .TAG_W(TAG_W)) u_match (
    .tag(cyc_addr[AW-1 -: TAG_W]), .space(cyc_space),
    .base(base_w), .mask(mask_w), .ctrl(ctrl_w), .boot(boot_w),
    .hit(hit_w), .sel_oh(sel_oh_w), .sel_ctrl(sel_ctrl_w)
  );

  csdec_timer #(.NUM_CS(NUM_CS)) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .start(cyc_start), .hit(hit_w),
    .sel_oh(sel_oh_w), .sel_ctrl(sel_ctrl_w), .ext_ack(ext_ack),
    .cs_act(cs_act), .ta(ta), .port_size(port_size),
    .burst_rd(burst_rd), .burst_wr(burst_wr)
  );
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
  parameter int NUM_CS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic [NUM_CS-1:0] cs_act,
  input logic              ta
);
  // R9
  single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_act));

  // R7
  ack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta |-> (cs_act != '0));

  // R9
  release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> (cs_act == '0));

  // R11
  hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_act != '0) && !ta) |=> (cs_act == $past(cs_act)));

  // R4
  start_before_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act != '0) |-> $past(cyc_start));
endmodule

bind csdec_top csdec_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cs_act(cs_act), .ta(ta)
);

// File: tb/csdec_top_bench.sv
module csdec_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [1:0]  cfg_field;
  logic [15:0] cfg_data;
  logic        cyc_start;
  logic [31:0] cyc_addr;
  logic [2:0]  cyc_space;
  logic        ext_ack;
  logic [4:0]  cs_act;
  logic        ta;
  logic [1:0]  port_size;
  logic        burst_rd, burst_wr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  csdec_top u_csdec_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .cyc_start(cyc_start),
    .cyc_addr(cyc_addr), .cyc_space(cyc_space), .ext_ack(ext_ack),
    .cs_act(cs_act), .ta(ta), .port_size(port_size),
    .burst_rd(burst_rd), .burst_wr(burst_wr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  space;
    logic [5:0]  ack_at;
    logic [4:0]  sel;
    logic [5:0]  len;
    logic [5:0]  ta_at;
    logic [1:0]  ps;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0010, 3'd0, 6'd63, 5'b00010, 6'd3, 6'd2,  2'd1, 4'd6},
    '{32'h10FF_0000, 3'd3, 6'd63, 5'b00010, 6'd3, 6'd2,  2'd1, 4'd4},
    '{32'h1100_0000, 3'd0, 6'd63, 5'b01000, 6'd2, 6'd1,  2'd0, 4'd4},
    '{32'h2ABC_0000, 3'd0, 6'd63, 5'b00100, 6'd1, 6'd0,  2'd0, 4'd7},
    '{32'h2000_0000, 3'd1, 6'd63, 5'b00000, 6'd0, 6'd63, 2'd0, 4'd5},
    '{32'h2000_0000, 3'd2, 6'd63, 5'b00100, 6'd1, 6'd0,  2'd0, 4'd5},
    '{32'h0FFF_FFFF, 3'd5, 6'd63, 5'b00001, 6'd4, 6'd3,  2'd2, 4'd10},
    '{32'h3000_0000, 3'd0, 6'd63, 5'b00000, 6'd0, 6'd63, 2'd0, 4'd4},
    '{32'h4000_0000, 3'd4, 6'd5,  5'b10000, 6'd6, 6'd5,  2'd3, 4'd8},
    '{32'h4001_0000, 3'd0, 6'd63, 5'b00000, 6'd0, 6'd63, 2'd0, 4'd4}
  };

  function automatic logic [15:0] ctrl_word(input logic v, input logic [5:0] sm,
      input logic [3:0] ws, input logic aa, input logic [1:0] ps,
      input logic br, input logic bw);
    return {bw, br, ps, aa, ws, sm, v};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] f, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_field = f; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  logic [4:0] r_sel;
  int         r_len, r_ta_at, r_ta_n;
  logic [1:0] r_ps;
  logic       r_br, r_bw;

  task automatic access(input logic [31:0] a, input logic [2:0] sp, input int ack_at,
                        input bit poke, input logic [31:0] poke_addr);
    r_sel = '0; r_len = 0; r_ta_at = 63; r_ta_n = 0; r_ps = '0; r_br = 0; r_bw = 0;
    @(negedge clk);
    cyc_start = 1'b1; cyc_addr = a; cyc_space = sp;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc_start = poke && (i == 0);
      if (poke && i == 0) cyc_addr = poke_addr;
      ext_ack = (i == ack_at);
      #1;
      if (cs_act != '0) begin
        if (r_sel == '0) begin
          r_sel = cs_act; r_ps = port_size; r_br = burst_rd; r_bw = burst_wr;
        end
        r_len++;
      end
      if (ta) begin r_ta_n++; r_ta_at = i; end
    end
    ext_ack = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_field = 0; cfg_data = 0;
    cyc_start = 0; cyc_addr = 0; cyc_space = 0; ext_ack = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "cs_act in reset", int'(cs_act), 0);
    chk("R1", "ta in reset", int'(ta), 0);
    chk("R1", "port_size in reset", int'(port_size), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "cs_act after reset", int'(cs_act), 0);

    // R2 boot select claims any address and space
    access(32'h7654_3210, 3'd3, 63, 0, 0);
    chk("R2", "boot sel", int'(r_sel), 1);
    chk("R2", "boot length", r_len, 16);
    chk("R2", "boot ta cycle", r_ta_at, 15);
    chk("R12", "boot port size", int'(r_ps), 2);
    chk("R12", "boot bursts", int'({r_br, r_bw}), 0);
    access(32'hFFFF_0000, 3'd5, 63, 0, 0);
    chk("R2", "boot sel dma", int'(r_sel), 1);

    // Select 1 valid while boot mode active: select 0 still wins (R6)
    wr(3'd1, 2'd0, 16'h1000);
    wr(3'd1, 2'd1, 16'h00FF);
    wr(3'd1, 2'd2, ctrl_word(1, 6'h00, 4'd2, 1, 2'd1, 1, 0));
    access(32'h1000_0000, 3'd0, 63, 0, 0);
    chk("R6", "boot select over select 1", int'(r_sel), 1);

    // R10 leave boot mode
    wr(3'd0, 2'd0, 16'h0000);
    wr(3'd0, 2'd1, 16'h0FFF);
    wr(3'd0, 2'd2, ctrl_word(1, 6'h00, 4'd3, 1, 2'd2, 0, 0));
    access(32'h5000_0000, 3'd0, 63, 0, 0);
    chk("R10", "no boot match", int'(r_sel), 0);
    chk("R10", "no ta on miss", r_ta_n, 0);

    // R3 invalid select with matching address stays quiet
    wr(3'd2, 2'd0, 16'h2000);
    wr(3'd2, 2'd1, 16'h0FFF);
    wr(3'd2, 2'd2, ctrl_word(0, 6'b000010, 4'd0, 1, 2'd0, 0, 0));
    access(32'h2000_0000, 3'd0, 63, 0, 0);
    chk("R3", "invalid select", int'(r_sel), 0);
    wr(3'd2, 2'd2, ctrl_word(1, 6'b000010, 4'd0, 1, 2'd0, 0, 0));
    wr(3'd3, 2'd0, 16'h1000);
    wr(3'd3, 2'd1, 16'h0FFF);
    wr(3'd3, 2'd2, ctrl_word(1, 6'h00, 4'd1, 1, 2'd0, 0, 0));
    wr(3'd4, 2'd0, 16'h4000);
    wr(3'd4, 2'd1, 16'h0000);
    wr(3'd4, 2'd2, ctrl_word(1, 6'h00, 4'd0, 0, 2'd3, 0, 1));

    // Vector table: R4 R5 R6 R7 R8 R10 R12
    for (int k = 0; k < NV; k++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[k].req);
      access(VECS[k].addr, VECS[k].space, int'(VECS[k].ack_at), 0, 0);
      chk(rq, $sformatf("vec %0d sel", k), int'(r_sel), int'(VECS[k].sel));
      chk(rq, $sformatf("vec %0d len", k), r_len, int'(VECS[k].len));
      chk(rq, $sformatf("vec %0d ta cycle", k), r_ta_at, int'(VECS[k].ta_at));
      if (VECS[k].sel != '0) begin
        chk("R12", $sformatf("vec %0d port size", k), int'(r_ps), int'(VECS[k].ps));
        chk("R9", $sformatf("vec %0d single ta", k), r_ta_n, 1);
      end
    end

    // R12 burst flags of select 1 and select 4
    access(32'h1000_0000, 3'd0, 63, 0, 0);
    chk("R12", "select 1 bursts rd/wr", int'({r_br, r_bw}), 2);
    access(32'h4000_0000, 3'd0, 2, 0, 0);
    chk("R12", "select 4 bursts rd/wr", int'({r_br, r_bw}), 1);
    chk("R8", "ext ack at 2 length", r_len, 3);

    // R5 codes 6 and 7 select nothing
    access(32'h1000_0000, 3'd6, 63, 0, 0);
    chk("R5", "space code 6", int'(r_sel), 0);

    // R11 start during active cycle ignored
    access(32'h1000_0000, 3'd0, 63, 1, 32'h2000_0000);
    chk("R11", "busy start sel", int'(r_sel), 2);
    chk("R11", "busy start length", r_len, 3);
    chk("R11", "busy start ta count", r_ta_n, 1);

    // R1 reset mid-cycle, R2 boot mode restored
    @(negedge clk);
    cyc_start = 1'b1; cyc_addr = 32'h1000_0000; cyc_space = 3'd0;
    @(negedge clk);
    cyc_start = 1'b0;
    #1;
    chk("R1", "active before reset", int'(cs_act), 2);
    rst_n = 1'b0;
    #1;
    chk("R1", "cs drops on reset", int'(cs_act), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    access(32'h5000_0000, 3'd0, 63, 0, 0);
    chk("R2", "boot restored", int'(r_sel), 1);
    chk("R2", "boot restored length", r_len, 16);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule